// File: doc/BRIEF.md
# Peripheral Security Access Gate

This block sits between one bus master and a bank of peripheral ports. Every request carries the index of the port it targets, together with a secure attribute and a privileged attribute. The gate checks those attributes against per-port configuration wires. It also checks them against a build-time mask that exempts chosen ports from the security-polarity test. A request that passes goes straight through to the selected port. The peripheral's ready, read data and error come back to the master in the same cycle.

A request that fails the check never reaches any peripheral. The gate answers it itself one cycle later. It returns either a bus error or a quiet success that reads as zero and drops the write. A failed request also sets a sticky violation flag. That flag, gated by an enable wire, forms the interrupt output. A clear wire empties the flag, and while the clear wire stays high it masks new violations.

Configuration inputs are captured into registers on every clock edge, and those registers reset to zero. Address decoding is done upstream: the port index arrives with the request.

Top module: `periph_sec_gate`

## Requirements
- R1: A permitted request raises only `dn_valid[up_port]`. Address, write flag, size, write data and both attributes reach the downstream bus unchanged. Size 0/1/2/3 means byte/halfword/word/doubleword, little-endian, and the gate passes it through as is. The selected port's ready, read data and error return to the master in the same cycle.
- R2: Security polarity is checked per port. When a port's `cfg_nonsec` bit is 1, secure requests to it are blocked. When that bit is 0, non-secure requests to it are blocked.
- R3: For each port whose bit in the parameter `NONSEC_MASK` is 1, the security-polarity check is skipped, so both secure and non-secure requests reach it.
- R4: An unprivileged request (`up_priv`=0) to a port whose `cfg_unpriv_ok` bit is 0 is blocked. This applies whatever the security check gives, including on masked ports.
- R5: A request whose port index is `NUM_PORTS` or higher is always blocked.
- R6: A blocked request raises no `dn_valid` bit. The gate asserts `up_ready` for it in the cycle after the request is first presented.
- R7: When the captured `cfg_err_resp` is 1, a blocked request completes with `up_err`=1 and zero read data. When it is 0, a blocked request completes with `up_err`=0 and zero read data, and no peripheral sees the write.
- R8: A blocked request sets a violation flag that stays set through later permitted traffic. `irq` is that flag ANDed with `irq_en`.
- R9: A clock edge with `irq_clr` high clears the violation flag. A blocked request decided at such an edge does not set it, so holding `irq_clr` high masks violations.
- R10: Reset clears the flag and the captured copies of `cfg_nonsec`, `cfg_unpriv_ok` and `cfg_err_resp`. A request presented before the first capture edge after reset is judged against all-zero configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Master request valid, held until `up_ready` |
| up_port | input | PORT_W | Target port index |
| up_addr | input | ADDR_W | Request address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | Access size code (0 byte … 3 doubleword) |
| up_wdata | input | DATA_W | Write data |
| up_secure | input | 1 | Secure attribute of the request |
| up_priv | input | 1 | Privileged attribute of the request |
| up_ready | output | 1 | Request completes this cycle |
| up_rdata | output | DATA_W | Read data returned to master |
| up_err | output | 1 | Error response |
| dn_valid | output | NUM_PORTS | Per-port request valid |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded write flag |
| dn_size | output | 2 | Forwarded size code |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_secure | output | 1 | Forwarded secure attribute |
| dn_priv | output | 1 | Forwarded privileged attribute |
| dn_ready | input | NUM_PORTS | Per-port ready |
| dn_rdata | input | NUM_PORTS*DATA_W | Per-port read data, port i at bits i*DATA_W upward |
| dn_err | input | NUM_PORTS | Per-port error |
| cfg_nonsec | input | NUM_PORTS | Per-port non-secure setting |
| cfg_unpriv_ok | input | NUM_PORTS | Per-port unprivileged-access permission |
| cfg_err_resp | input | 1 | 1 = error for blocked requests, 0 = read-zero/write-ignore |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Violation clear, masks new violations while high |
| irq | output | 1 | Violation interrupt |

## Verification
The check logic is driven with a port map that splits the ports into non-secure and secure halves. It is crossed with an unprivileged-permission pattern that differs from that split, so a polarity fault and a privilege fault block different requests. The masked port is hit with secure, non-secure and unprivileged requests; a missing bypass and a bypass that also skips the privilege test each show up there. Out-of-range indices, a peripheral that itself returns an error, and both blocked-response modes separate the gate's own answers from pass-through answers. Interrupt checks separate a single clear pulse, a held clear with a violation under it, and a flag that must survive later permitted traffic.

// File: rtl/psg_pkg.sv
`timescale 1ns/1ps
package psg_pkg;

    // Attributes a master attaches to each request.
    typedef struct packed {
        logic secure;
        logic priv;
    } bus_attr_t;

    // Per-port configuration as seen by the check.
    typedef struct packed {
        logic nonsec;
        logic unpriv_ok;
    } port_cfg_t;

    // 1 when the request may reach the port.
    function automatic logic attr_clears(bus_attr_t a, port_cfg_t c, logic skip_sec);
        logic sec_bad;
        logic priv_bad;
        sec_bad  = (a.secure == c.nonsec) && !skip_sec;
        priv_bad = !a.priv && !c.unpriv_ok;
        return !(sec_bad || priv_bad);
    endfunction

endpackage

// File: rtl/psg_check.sv
`timescale 1ns/1ps
module psg_check
    import psg_pkg::*;
#(
    parameter int                   NUM_PORTS   = 16,
    parameter int                   PORT_W      = 5,
    parameter logic [NUM_PORTS-1:0] NONSEC_MASK = '0
) (
    input  logic [PORT_W-1:0]    sel,
    input  bus_attr_t            attr,
    input  logic [NUM_PORTS-1:0] cfg_nonsec,
    input  logic [NUM_PORTS-1:0] cfg_unpriv_ok,
    output logic                 allow
);
    localparam int SEL_N = 1 << PORT_W;

    logic [SEL_N-1:0] ok;

    // Indices without a port evaluate to "blocked".
    generate
        for (genvar i = 0; i < SEL_N; i++) begin : g_port
            if (i < NUM_PORTS) begin : g_real
                port_cfg_t c;
                assign c     = '{nonsec: cfg_nonsec[i], unpriv_ok: cfg_unpriv_ok[i]};
                assign ok[i] = attr_clears(attr, c, NONSEC_MASK[i]);
            end else begin : g_none
                assign ok[i] = 1'b0;
            end
        end
    endgenerate

    assign allow = ok[sel];

endmodule

// File: rtl/psg_route.sv
`timescale 1ns/1ps
module psg_route #(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = 5,
    parameter int DATA_W    = 64
) (
    input  logic                        fwd,
    input  logic [PORT_W-1:0]           sel,
    output logic [NUM_PORTS-1:0]        dn_valid,
    input  logic [NUM_PORTS-1:0]        dn_ready,
    input  logic [NUM_PORTS*DATA_W-1:0] dn_rdata,
    input  logic [NUM_PORTS-1:0]        dn_err,
    output logic                        sel_ready,
    output logic                        sel_err,
    output logic [DATA_W-1:0]           sel_rdata
);
    always_comb begin
        dn_valid  = '0;
        sel_ready = 1'b0;
        sel_err   = 1'b0;
        sel_rdata = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel == PORT_W'(i)) begin
                dn_valid[i] = fwd;
                sel_ready   = dn_ready[i];
                sel_err     = dn_err[i];
                sel_rdata   = dn_rdata[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/psg_viol.sv
`timescale 1ns/1ps
module psg_viol (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    input  logic en,
    output logic irq
);
    logic flag_q;

    // Clear wins over a simultaneous violation.
    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (clr) flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
    end

    assign irq = flag_q & en;

endmodule

// File: rtl/periph_sec_gate.sv
`timescale 1ns/1ps
module periph_sec_gate
    import psg_pkg::*;
#(
    parameter int                   NUM_PORTS   = 16,
    parameter int                   ADDR_W      = 32,
    parameter int                   DATA_W      = 64,
    parameter logic [NUM_PORTS-1:0] NONSEC_MASK = '0,
    localparam int                  PORT_W      = $clog2(NUM_PORTS) + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        up_valid,
    input  logic [PORT_W-1:0]           up_port,
    input  logic [ADDR_W-1:0]           up_addr,
    input  logic                        up_write,
    input  logic [1:0]                  up_size,
    input  logic [DATA_W-1:0]           up_wdata,
    input  logic                        up_secure,
    input  logic                        up_priv,
    output logic                        up_ready,
    output logic [DATA_W-1:0]           up_rdata,
    output logic                        up_err,
    output logic [NUM_PORTS-1:0]        dn_valid,
    output logic [ADDR_W-1:0]           dn_addr,
    output logic                        dn_write,
    output logic [1:0]                  dn_size,
    output logic [DATA_W-1:0]           dn_wdata,
    output logic                        dn_secure,
    output logic                        dn_priv,
    input  logic [NUM_PORTS-1:0]        dn_ready,
    input  logic [NUM_PORTS*DATA_W-1:0] dn_rdata,
    input  logic [NUM_PORTS-1:0]        dn_err,
    input  logic [NUM_PORTS-1:0]        cfg_nonsec,
    input  logic [NUM_PORTS-1:0]        cfg_unpriv_ok,
    input  logic                        cfg_err_resp,
    input  logic                        irq_en,
    input  logic                        irq_clr,
    output logic                        irq
);
    // Captured configuration.
    logic [NUM_PORTS-1:0] nonsec_q;
    logic [NUM_PORTS-1:0] unpriv_ok_q;
    logic                 err_mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nonsec_q    <= '0;
            unpriv_ok_q <= '0;
            err_mode_q  <= 1'b0;
        end else begin
            nonsec_q    <= cfg_nonsec;
            unpriv_ok_q <= cfg_unpriv_ok;
            err_mode_q  <= cfg_err_resp;
        end
    end

    bus_attr_t req_attr;
    logic      allow;

    assign req_attr = '{secure: up_secure, priv: up_priv};

    psg_check #(
        .NUM_PORTS  (NUM_PORTS),
        .PORT_W     (PORT_W),
        .NONSEC_MASK(NONSEC_MASK)
    ) u_check (
        .sel          (up_port),
        .attr         (req_attr),
        .cfg_nonsec   (nonsec_q),
        .cfg_unpriv_ok(unpriv_ok_q),
        .allow        (allow)
    );

    // Local answer for a blocked request, one cycle after it appears.
    logic blk_q;
    logic blk_err_q;
    logic blk_start;
    logic fwd;

    assign blk_start = up_valid && !allow && !blk_q;
    assign fwd       = up_valid &&  allow && !blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q     <= 1'b0;
            blk_err_q <= 1'b0;
        end else begin
            blk_q <= blk_start;
            if (blk_start) blk_err_q <= err_mode_q;
        end
    end

    logic              sel_ready;
    logic              sel_err;
    logic [DATA_W-1:0] sel_rdata;

    psg_route #(
        .NUM_PORTS(NUM_PORTS),
        .PORT_W   (PORT_W),
        .DATA_W   (DATA_W)
    ) u_route (
        .fwd      (fwd),
        .sel      (up_port),
        .dn_valid (dn_valid),
        .dn_ready (dn_ready),
        .dn_rdata (dn_rdata),
        .dn_err   (dn_err),
        .sel_ready(sel_ready),
        .sel_err  (sel_err),
        .sel_rdata(sel_rdata)
    );

    psg_viol u_viol (
        .clk(clk),
        .rst(rst),
        .hit(blk_start),
        .clr(irq_clr),
        .en (irq_en),
        .irq(irq)
    );

    assign dn_addr   = up_addr;
    assign dn_write  = up_write;
    assign dn_size   = up_size;
    assign dn_wdata  = up_wdata;
    assign dn_secure = up_secure;
    assign dn_priv   = up_priv;

    assign up_ready = blk_q || (fwd && sel_ready);
    assign up_rdata = blk_q ? '0 : sel_rdata;
    assign up_err   = blk_q ? blk_err_q : sel_err;

endmodule

// File: rtl/psg_sva.sv
`timescale 1ns/1ps
module psg_sva #(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = 5,
    parameter int DATA_W    = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 up_valid,
    input logic [PORT_W-1:0]    up_port,
    input logic                 up_ready,
    input logic [DATA_W-1:0]    up_rdata,
    input logic [NUM_PORTS-1:0] dn_valid,
    input logic                 irq_en,
    input logic                 irq_clr,
    input logic                 irq
);
    AST_ONE_PORT_ONLY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dn_valid)); // R1

    AST_RANGE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_port >= PORT_W'(NUM_PORTS)) |-> dn_valid == '0); // R5

    AST_BLOCK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (up_valid && dn_valid == '0 && !up_ready) |=> up_ready); // R6

    AST_LOCAL_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (up_ready && dn_valid == '0) |-> up_rdata == '0); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> (irq || !irq_en)); // R8

    AST_CLEAR_MASKS: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> !irq); // R9

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq); // R10

endmodule

bind periph_sec_gate psg_sva #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_W   (PORT_W),
    .DATA_W   (DATA_W)
) u_sva (
    .clk     (clk),
    .rst     (rst),
    .up_valid(up_valid),
    .up_port (up_port),
    .up_ready(up_ready),
    .up_rdata(up_rdata),
    .dn_valid(dn_valid),
    .irq_en  (irq_en),
    .irq_clr (irq_clr),
    .irq     (irq)
);

// File: tb/sim_periph_sec_gate.sv
`timescale 1ns/1ps
module sim_periph_sec_gate;
    localparam int             NP   = 16;
    localparam int             AW   = 32;
    localparam int             DW   = 64;
    localparam int             PW   = 5;
    localparam logic [NP-1:0]  MASK = 16'h8000;
    localparam logic [AW-1:0]  BAD_ADDR = 32'hBAD0_0000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst;
    logic             up_valid;
    logic [PW-1:0]    up_port;
    logic [AW-1:0]    up_addr;
    logic             up_write;
    logic [1:0]       up_size;
    logic [DW-1:0]    up_wdata;
    logic             up_secure;
    logic             up_priv;
    logic             up_ready;
    logic [DW-1:0]    up_rdata;
    logic             up_err;
    logic [NP-1:0]    dn_valid;
    logic [AW-1:0]    dn_addr;
    logic             dn_write;
    logic [1:0]       dn_size;
    logic [DW-1:0]    dn_wdata;
    logic             dn_secure;
    logic             dn_priv;
    logic [NP-1:0]    dn_ready;
    logic [NP*DW-1:0] dn_rdata;
    logic [NP-1:0]    dn_err;
    logic [NP-1:0]    cfg_nonsec;
    logic [NP-1:0]    cfg_unpriv_ok;
    logic             cfg_err_resp;
    logic             irq_en;
    logic             irq_clr;
    logic             irq;

    periph_sec_gate #(
        .NUM_PORTS  (NP),
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .NONSEC_MASK(MASK)
    ) u0 (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_port(up_port), .up_addr(up_addr),
        .up_write(up_write), .up_size(up_size), .up_wdata(up_wdata),
        .up_secure(up_secure), .up_priv(up_priv),
        .up_ready(up_ready), .up_rdata(up_rdata), .up_err(up_err),
        .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_write(dn_write),
        .dn_size(dn_size), .dn_wdata(dn_wdata), .dn_secure(dn_secure),
        .dn_priv(dn_priv), .dn_ready(dn_ready), .dn_rdata(dn_rdata),
        .dn_err(dn_err),
        .cfg_nonsec(cfg_nonsec), .cfg_unpriv_ok(cfg_unpriv_ok),
        .cfg_err_resp(cfg_err_resp), .irq_en(irq_en), .irq_clr(irq_clr),
        .irq(irq)
    );

    // Peripheral model: always ready, data tags port and address.
    function automatic logic [DW-1:0] model_rd(int p, logic [AW-1:0] a);
        return {16'hC0DE, 8'h00, 8'(p), a};
    endfunction

    assign dn_ready = dn_valid;
    for (genvar p = 0; p < NP; p++) begin : g_periph
        assign dn_rdata[p*DW +: DW] = model_rd(p, dn_addr);
        assign dn_err[p]            = (dn_addr == BAD_ADDR);
    end

    logic [DW-1:0] last_wd [NP];
    int            wr_cnt = 0;
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (dn_valid[p] && dn_ready[p] && dn_write) begin
                last_wd[p] <= dn_wdata;
                wr_cnt     <= wr_cnt + 1;
            end
        end
    end

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Scoreboard.
    typedef struct {
        bit            fwd;
        int            port;
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
        bit            err;
        string         req;
    } exp_t;

    exp_t sbq[$];

    always @(negedge clk) begin
        exp_t          e;
        logic [NP-1:0] dnv;
        if (!rst && up_valid && up_ready) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R6", "handshake with nothing expected", 1, 0);
            end else begin
                e   = sbq.pop_front();
                dnv = e.fwd ? (NP'(1) << e.port) : '0;
                chk(up_err == e.err, e.req, "up_err", DW'(up_err), DW'(e.err));
                chk(up_rdata == e.rd, e.req, "up_rdata", up_rdata, e.rd);
                chk(dn_valid == dnv, e.req, "dn_valid", DW'(dn_valid), DW'(dnv));
                if (e.fwd)
                    chk(dn_addr == e.addr && dn_wdata == e.wd && dn_write == e.wr &&
                        dn_size == up_size && dn_secure == up_secure && dn_priv == up_priv,
                        e.req, "forwarded fields", DW'(dn_addr), DW'(e.addr));
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Driver: called at posedge+2, returns at posedge+2.
    task automatic access(int port, bit wr, bit sec, bit priv, logic [AW-1:0] addr,
                          bit fwd, bit blk_err, string req);
        exp_t e;
        int   lat;
        e.fwd  = fwd;
        e.port = port;
        e.wr   = wr;
        e.addr = addr;
        e.wd   = {addr, ~addr};
        e.rd   = fwd ? model_rd(port, addr) : '0;
        e.err  = fwd ? (addr == BAD_ADDR) : blk_err;
        e.req  = req;
        sbq.push_back(e);
        up_valid  = 1'b1;
        up_port   = PW'(port);
        up_write  = wr;
        up_secure = sec;
        up_priv   = priv;
        up_addr   = addr;
        up_wdata  = e.wd;
        up_size   = 2'(port & 3);
        lat = 0;
        @(negedge clk);
        while (!up_ready) begin
            lat++;
            @(negedge clk);
        end
        chk(lat == (fwd ? 0 : 1), req, "response latency", DW'(lat), DW'(fwd ? 0 : 1));
        @(posedge clk);
        #2;
        up_valid = 1'b0;
        if (fwd && wr)
            chk(last_wd[port] == e.wd, req, "peripheral write data", last_wd[port], e.wd);
    endtask

    initial begin
        int cnt;
        rst = 1'b1; up_valid = 1'b0; up_port = '0; up_addr = '0; up_write = 1'b0;
        up_size = '0; up_wdata = '0; up_secure = 1'b0; up_priv = 1'b0;
        cfg_nonsec = '1; cfg_unpriv_ok = '1; cfg_err_resp = 1'b1;
        irq_en = 1'b0; irq_clr = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!up_ready && dn_valid == '0 && !irq, "R10", "outputs in reset",
            DW'({up_ready, irq}), 0);
        step(1);
        rst = 1'b0;

        // R10: captured config still zero -> non-secure blocked, quiet answer.
        access(0, 0, 0, 1, 32'h0000_0100, 0, 0, "R10");
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8", "flag after first block", DW'(irq), 1);
        step(1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R9", "clear pulse", DW'(irq), 0);
        step(1);

        cfg_nonsec    = 16'h00FF;
        cfg_unpriv_ok = 16'h0F0F;
        cfg_err_resp  = 1'b1;
        step(1);

        access(3, 0, 0, 1, 32'h0000_0304, 1, 0, "R1");
        access(3, 0, 1, 1, 32'h0000_0308, 0, 1, "R2");
        access(9, 1, 1, 1, 32'h0000_0900, 1, 0, "R1");
        access(9, 0, 0, 1, 32'h0000_0904, 0, 1, "R2");
        access(1, 0, 0, 0, 32'h0000_0110, 1, 0, "R4");
        access(5, 0, 0, 0, 32'h0000_0510, 0, 1, "R4");
        access(14, 0, 0, 1, 32'h0000_0E00, 0, 1, "R3");
        access(15, 0, 0, 1, 32'h0000_0F00, 1, 0, "R3");
        access(15, 1, 1, 1, 32'h0000_0F04, 1, 0, "R3");
        access(15, 0, 0, 0, 32'h0000_0F08, 0, 1, "R4");
        access(16, 0, 1, 1, 32'h0000_0000, 0, 1, "R5");
        access(31, 1, 0, 1, 32'h0000_0004, 0, 1, "R5");
        access(2, 0, 0, 1, BAD_ADDR, 1, 0, "R1");

        cfg_err_resp = 1'b0;
        step(1);
        cnt = wr_cnt;
        access(9, 1, 0, 1, 32'h0000_0908, 0, 0, "R7");
        chk(last_wd[9] == {32'h0000_0900, ~32'h0000_0900} && wr_cnt == cnt, "R7",
            "blocked write discarded", last_wd[9], {32'h0000_0900, ~32'h0000_0900});
        access(8, 0, 0, 1, 32'h0000_0800, 0, 0, "R7");

        // R8: flag set; enable gates the output.
        irq_en = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R8", "irq with enable low", DW'(irq), 0);
        step(1);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8", "irq with enable high", DW'(irq), 1);
        step(1);

        // R9: violation under a held clear leaves no flag.
        irq_clr = 1'b1;
        step(1);
        access(5, 0, 0, 0, 32'h0000_0520, 0, 0, "R9");
        irq_clr = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R9", "held clear masks violation", DW'(irq), 0);
        step(1);

        // R8: flag survives later permitted traffic.
        access(8, 0, 0, 1, 32'h0000_0810, 0, 0, "R8");
        access(3, 0, 0, 1, 32'h0000_0310, 1, 0, "R8");
        @(negedge clk);
        chk(irq == 1'b1, "R8", "flag sticky", DW'(irq), 1);

        step(2);
        chk(sbq.size() == 0, "R6", "every request answered", DW'(sbq.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule